// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits beside the transmit and receive FIFOs of an SPI controller and turns their fill levels and push/pop strobes into status flags, interrupt sources and DMA requests. The FIFO arrays and the serial shifter live elsewhere. They report their occupancy on level inputs and signal each push and pop on single-cycle strobes. Software reaches the unit through a small write port that selects one of seven registers. The four threshold registers can also be read back.

Two interrupt sources come straight from the fill levels and are not latched. One is transmit low water, raised while the transmit level is at or below its threshold. The other is receive high water, raised while the receive level is strictly above its threshold. Three error sources are sticky: transmit overflow, receive underflow and receive overflow. Each can be cleared on its own, or all together with one bit. A threshold write is dropped when the value is at or beyond the FIFO depth, so software can find the depth by writing a value and reading it back. Threshold writes are also dropped while the controller is enabled.

The unit has no state machine. All state sits in plain registers: the mask, the DMA enables, the four thresholds and the three sticky error bits.

Top module: `spi_fsi_unit`

## Requirements
- R1: `status` bit 0 is `busy_in`, bit 1 is transmit full (level equals DEPTH), bit 2 is transmit empty (level 0), bit 3 is receive empty and bit 4 is receive full.
- R2: `raw_irq` bit 0 is high while `tx_level` is at most the transmit threshold. `raw_irq` bit 4 is high while `rx_level` is strictly greater than the receive threshold. Neither bit is latched.
- R3: The sticky error bits are set one cycle after their event and then hold. `raw_irq` bit 1 is set by `tx_push` at a full transmit FIFO. Bit 2 is set by `rx_pop` at an empty receive FIFO. Bit 3 is set by `rx_push` at a full receive FIFO.
- R4: A write with `wr_sel`=1 (clear register) clears sticky bits. Data bit 0 clears all three, bit 1 clears receive underflow, bit 2 clears receive overflow and bit 3 clears transmit overflow.
- R5: If a sticky event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: `masked_irq` equals `raw_irq` AND the 5-bit mask register (`wr_sel`=0), and `irq` is the OR of `masked_irq`.
- R7: `tx_dma_req` is high while the DMA enable register (`wr_sel`=4) has bit 1 set and `tx_level` is at most the transmit DMA level (`wr_sel`=5).
- R8: `rx_dma_req` is high while the DMA enable register has bit 0 set and `rx_level` is strictly above the receive DMA level (`wr_sel`=6).
- R9: A write to a threshold register (`wr_sel` 2 transmit, 3 receive, 5 transmit DMA, 6 receive DMA) whose value is DEPTH or more leaves the register unchanged. A smaller value is stored and appears on its read-back port one cycle later.
- R10: While `ctrl_en` is high, writes to the four threshold registers are ignored.
- R11: After reset the mask, the DMA enables, all thresholds and all sticky bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enabled; locks the thresholds |
| busy_in | input | 1 | Shifter busy flag |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| tx_push | input | 1 | Write into the transmit FIFO this cycle |
| rx_push | input | 1 | Shifter write into the receive FIFO this cycle |
| rx_pop | input | 1 | Read from the receive FIFO this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | DW | Register write data |
| status | output | 5 | Status flags |
| raw_irq | output | 5 | Unmasked interrupt sources |
| masked_irq | output | 5 | Interrupt sources after the mask |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_thr_rd | output | TH_W | Transmit threshold read-back |
| rx_thr_rd | output | TH_W | Receive threshold read-back |
| tx_dlvl_rd | output | TH_W | Transmit DMA level read-back |
| rx_dlvl_rd | output | TH_W | Receive DMA level read-back |

## Verification
The threshold comparators are swept across every threshold and every level from 0 to DEPTH. This separates the at-or-below test on the transmit side from the strictly-above test on the receive side, and it exposes any off-by-one at the boundary. The DMA requests are swept across all four enable combinations as well, so a swapped enable bit shows up.

Every threshold write value from 0 to 15 is tried. This tells an accepted value apart from one that is out of range, and the lock during enable is tested separately.

All sixteen clear-data patterns are applied to a fully set error vector, which separates the per-source clear bits from the clear-all bit. A coincident event and clear shows which of the two wins. All 32 mask values are applied to two different raw vectors.

// File: rtl/spi_fsi_pkg.sv
package spi_fsi_pkg;
    typedef enum logic [2:0] {
        SEL_MASK   = 3'd0,
        SEL_CLEAR  = 3'd1,
        SEL_TXTH   = 3'd2,
        SEL_RXTH   = 3'd3,
        SEL_DMACTL = 3'd4,
        SEL_TXDL   = 3'd5,
        SEL_RXDL   = 3'd6
    } reg_sel_e;

    localparam int IRQ_W   = 5;
    localparam int IRQ_TXE = 0;
    localparam int IRQ_TXO = 1;
    localparam int IRQ_RXU = 2;
    localparam int IRQ_RXO = 3;
    localparam int IRQ_RXF = 4;

    localparam int CLR_ALL = 0;
    localparam int CLR_RXU = 1;
    localparam int CLR_RXO = 2;
    localparam int CLR_TXO = 3;

    localparam int DMA_RX_EN = 0;
    localparam int DMA_TX_EN = 1;

    // sticky slot order inside the error register bank
    localparam int STK_N   = 3;
    localparam int STK_TXO = 0;
    localparam int STK_RXU = 1;
    localparam int STK_RXO = 2;
endpackage

// File: rtl/spi_fsi_thr_bank.sv
module spi_fsi_thr_bank #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int NREG  = 4,
    localparam int TH_W = $clog2(DEPTH),
    localparam int IX_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lock,
    input  logic                       wr_en,
    input  logic [IX_W-1:0]            wr_idx,
    input  logic [DW-1:0]              wr_data,
    output logic [NREG-1:0][TH_W-1:0]  thr_q
);
    localparam logic [DW-1:0] DEPTH_D = DW'(DEPTH);

    logic in_range;
    assign in_range = (wr_data < DEPTH_D);

    for (genvar g = 0; g < NREG; g++) begin : g_thr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                thr_q[g] <= '0;
            end else if (wr_en && !lock && in_range && (wr_idx == IX_W'(g))) begin
                thr_q[g] <= wr_data[TH_W-1:0];
            end
        end
    end
endmodule

// File: rtl/spi_fsi_sticky.sv
module spi_fsi_sticky #(
    parameter int NB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_i,
    input  logic [NB-1:0] clr_i,
    output logic [NB-1:0] q
);
    for (genvar g = 0; g < NB; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[g] <= 1'b0;
            end else if (set_i[g]) begin
                q[g] <= 1'b1;      // an event outranks a clear
            end else if (clr_i[g]) begin
                q[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_fsi_level_cmp.sv
module spi_fsi_level_cmp #(
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int TH_W  = $clog2(DEPTH)
) (
    input  logic [LVL_W-1:0] level,
    input  logic [TH_W-1:0]  irq_thr,
    input  logic [TH_W-1:0]  dma_thr,
    input  logic             above_mode,
    output logic             is_full,
    output logic             is_empty,
    output logic             irq_hit,
    output logic             dma_hit
);
    localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);

    logic [LVL_W-1:0] irq_thr_x;
    logic [LVL_W-1:0] dma_thr_x;

    always_comb begin
        irq_thr_x = LVL_W'(irq_thr);
        dma_thr_x = LVL_W'(dma_thr);
        is_full   = (level == FULL_L);
        is_empty  = (level == '0);
        if (above_mode) begin
            irq_hit = (level > irq_thr_x);
            dma_hit = (level > dma_thr_x);
        end else begin
            irq_hit = (level <= irq_thr_x);
            dma_hit = (level <= dma_thr_x);
        end
    end
endmodule

// File: rtl/spi_fsi_unit.sv
module spi_fsi_unit
    import spi_fsi_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int TH_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic             busy_in,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             tx_push,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [DW-1:0]    wr_data,
    output logic [4:0]       status,
    output logic [4:0]       raw_irq,
    output logic [4:0]       masked_irq,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req,
    output logic [TH_W-1:0]  tx_thr_rd,
    output logic [TH_W-1:0]  rx_thr_rd,
    output logic [TH_W-1:0]  tx_dlvl_rd,
    output logic [TH_W-1:0]  rx_dlvl_rd
);
    localparam int NTHR = 4;

    reg_sel_e               sel;
    logic [IRQ_W-1:0]       mask_q;
    logic [1:0]             dma_en_q;
    logic                   thr_wr;
    logic [1:0]             thr_idx;
    logic [NTHR-1:0][TH_W-1:0] thr_q;
    logic                   clr_wr;
    logic [STK_N-1:0]       stk_set;
    logic [STK_N-1:0]       stk_clr;
    logic [STK_N-1:0]       stk_q;
    logic                   tx_full, tx_empty, tx_low, tx_dma_hit;
    logic                   rx_full, rx_empty, rx_high, rx_dma_hit;

    assign sel = reg_sel_e'(wr_sel);

    // write decode for the threshold bank
    always_comb begin
        thr_wr  = wr_en;
        thr_idx = 2'd0;
        unique case (sel)
            SEL_TXTH: thr_idx = 2'd0;
            SEL_RXTH: thr_idx = 2'd1;
            SEL_TXDL: thr_idx = 2'd2;
            SEL_RXDL: thr_idx = 2'd3;
            default:  thr_wr  = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            dma_en_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_MASK)   mask_q   <= wr_data[IRQ_W-1:0];
            if (sel == SEL_DMACTL) dma_en_q <= wr_data[1:0];
        end
    end

    spi_fsi_thr_bank #(.DEPTH(DEPTH), .DW(DW), .NREG(NTHR)) u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (ctrl_en),
        .wr_en   (thr_wr),
        .wr_idx  (thr_idx),
        .wr_data (wr_data),
        .thr_q   (thr_q)
    );

    assign tx_thr_rd  = thr_q[0];
    assign rx_thr_rd  = thr_q[1];
    assign tx_dlvl_rd = thr_q[2];
    assign rx_dlvl_rd = thr_q[3];

    spi_fsi_level_cmp #(.DEPTH(DEPTH)) u_txcmp (
        .level      (tx_level),
        .irq_thr    (thr_q[0]),
        .dma_thr    (thr_q[2]),
        .above_mode (1'b0),
        .is_full    (tx_full),
        .is_empty   (tx_empty),
        .irq_hit    (tx_low),
        .dma_hit    (tx_dma_hit)
    );

    spi_fsi_level_cmp #(.DEPTH(DEPTH)) u_rxcmp (
        .level      (rx_level),
        .irq_thr    (thr_q[1]),
        .dma_thr    (thr_q[3]),
        .above_mode (1'b1),
        .is_full    (rx_full),
        .is_empty   (rx_empty),
        .irq_hit    (rx_high),
        .dma_hit    (rx_dma_hit)
    );

    // sticky error sources
    assign clr_wr = wr_en && (sel == SEL_CLEAR);

    always_comb begin
        stk_set          = '0;
        stk_set[STK_TXO] = tx_push && tx_full;
        stk_set[STK_RXU] = rx_pop  && rx_empty;
        stk_set[STK_RXO] = rx_push && rx_full;
        stk_clr          = '0;
        if (clr_wr) begin
            stk_clr[STK_TXO] = wr_data[CLR_ALL] | wr_data[CLR_TXO];
            stk_clr[STK_RXU] = wr_data[CLR_ALL] | wr_data[CLR_RXU];
            stk_clr[STK_RXO] = wr_data[CLR_ALL] | wr_data[CLR_RXO];
        end
    end

    spi_fsi_sticky #(.NB(STK_N)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (stk_set),
        .clr_i (stk_clr),
        .q     (stk_q)
    );

    always_comb begin
        status     = {rx_full, rx_empty, tx_empty, tx_full, busy_in};
        raw_irq    = '0;
        raw_irq[IRQ_TXE] = tx_low;
        raw_irq[IRQ_TXO] = stk_q[STK_TXO];
        raw_irq[IRQ_RXU] = stk_q[STK_RXU];
        raw_irq[IRQ_RXO] = stk_q[STK_RXO];
        raw_irq[IRQ_RXF] = rx_high;
        masked_irq = raw_irq & mask_q;
        irq        = |masked_irq;
        tx_dma_req = dma_en_q[DMA_TX_EN] && tx_dma_hit;
        rx_dma_req = dma_en_q[DMA_RX_EN] && rx_dma_hit;
    end
endmodule

// File: rtl/spi_fsi_checks.sv
module spi_fsi_checks #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int TH_W  = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_en,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             tx_push,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic [DW-1:0]    wr_data,
    input logic [4:0]       status,
    input logic [4:0]       raw_irq,
    input logic [4:0]       masked_irq,
    input logic             tx_dma_req,
    input logic             rx_dma_req,
    input logic [TH_W-1:0]  tx_thr_rd,
    input logic [TH_W-1:0]  rx_thr_rd,
    input logic [TH_W-1:0]  tx_dlvl_rd,
    input logic [TH_W-1:0]  rx_dlvl_rd
);
    logic clr_all_wr;
    logic any_evt;
    assign clr_all_wr = wr_en && (wr_sel == 3'd1) && wr_data[0];
    assign any_evt    = (tx_push && status[1]) || (rx_pop && status[3]) || (rx_push && status[4]);

    a_r3_txovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && status[1]) |=> raw_irq[1]);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_sel == 3'd1) && !any_evt) |=> (raw_irq[3:1] == $past(raw_irq[3:1])));

    a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all_wr && !any_evt) |=> (raw_irq[3:1] == 3'b000));

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all_wr && rx_pop && status[3]) |=> raw_irq[2]);

    a_r6_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked_irq & ~raw_irq) == 5'b0));

    a_r7_txdma: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> (tx_level <= LVL_W'(tx_dlvl_rd)));

    a_r8_rxdma: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (rx_level > LVL_W'(rx_dlvl_rd)));

    a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en |=> ($stable(tx_thr_rd) && $stable(rx_thr_rd) &&
                     $stable(tx_dlvl_rd) && $stable(rx_dlvl_rd)));
endmodule

bind spi_fsi_unit spi_fsi_checks #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_en    (ctrl_en),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .tx_push    (tx_push),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .status     (status),
    .raw_irq    (raw_irq),
    .masked_irq (masked_irq),
    .tx_dma_req (tx_dma_req),
    .rx_dma_req (rx_dma_req),
    .tx_thr_rd  (tx_thr_rd),
    .rx_thr_rd  (rx_thr_rd),
    .tx_dlvl_rd (tx_dlvl_rd),
    .rx_dlvl_rd (rx_dlvl_rd)
);

// File: tb/sim_spi_fsi_unit.sv
`timescale 1ns/1ps
module sim_spi_fsi_unit;
    localparam int DEPTH = 8;
    localparam int DW    = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int TH_W  = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctrl_en = 1'b0;
    logic             busy_in = 1'b0;
    logic [LVL_W-1:0] tx_level = '0;
    logic [LVL_W-1:0] rx_level = '0;
    logic             tx_push = 1'b0;
    logic             rx_push = 1'b0;
    logic             rx_pop = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_sel = '0;
    logic [DW-1:0]    wr_data = '0;
    logic [4:0]       status, raw_irq, masked_irq;
    logic             irq, tx_dma_req, rx_dma_req;
    logic [TH_W-1:0]  tx_thr_rd, rx_thr_rd, tx_dlvl_rd, rx_dlvl_rd;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    spi_fsi_unit #(.DEPTH(DEPTH), .DW(DW)) u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = DW'(data);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic set_levels(input int t, input int r);
        @(negedge clk);
        tx_level = LVL_W'(t); rx_level = LVL_W'(r);
        #1;
    endtask

    // raise all three sticky bits: tx overflow and rx underflow, then rx overflow
    task automatic set_all_sticky();
        @(negedge clk);
        tx_level = LVL_W'(DEPTH); rx_level = '0; tx_push = 1'b1; rx_pop = 1'b1;
        @(negedge clk);
        tx_push = 1'b0; rx_pop = 1'b0; rx_level = LVL_W'(DEPTH); rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int prev;
        int exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state (levels 0, thresholds 0 -> only tx low-water raw)
        check("R11 status", status, 5'b01100);
        check("R11 raw", raw_irq, 5'b00001);
        check("R11 masked", masked_irq, 0);
        check("R11 irq", irq, 0);
        check("R11 txdma", tx_dma_req, 0);
        check("R11 rxdma", rx_dma_req, 0);
        check("R11 thr", {tx_thr_rd, rx_thr_rd, tx_dlvl_rd, rx_dlvl_rd}, 0);

        // R1 status sweep
        for (int b = 0; b < 2; b++) begin
            for (int l = 0; l <= DEPTH; l++) begin
                @(negedge clk);
                busy_in = b[0]; tx_level = LVL_W'(l); rx_level = LVL_W'(DEPTH - l);
                #1;
                exp = b | ((l == DEPTH) << 1) | ((l == 0) << 2) |
                      (((DEPTH - l) == 0) << 3) | (((DEPTH - l) == DEPTH) << 4);
                check("R1 status", status, exp);
            end
        end
        busy_in = 1'b0;

        // R2 level-derived interrupts for every threshold and level
        for (int th = 0; th < DEPTH; th++) begin
            wr(2, th);
            wr(3, th);
            for (int l = 0; l <= DEPTH; l++) begin
                set_levels(l, l);
                check("R2 tx low", raw_irq[0], (l <= th) ? 1 : 0);
                check("R2 rx high", raw_irq[4], (l > th) ? 1 : 0);
            end
        end

        // R9 range filter on threshold writes
        wr(2, 0); wr(6, 0);
        prev = 0;
        for (int v = 0; v < 16; v++) begin
            wr(2, v);
            wr(6, v);
            if (v < DEPTH) prev = v;
            check("R9 tx thr", tx_thr_rd, prev);
            check("R9 rx dlvl", rx_dlvl_rd, prev);
        end

        // R10 lock while enabled
        wr(3, 2); wr(5, 1);
        ctrl_en = 1'b1;
        wr(3, 5); wr(5, 6); wr(2, 1); wr(6, 3);
        check("R10 rx thr", rx_thr_rd, 2);
        check("R10 tx dlvl", tx_dlvl_rd, 1);
        check("R10 tx thr", tx_thr_rd, 7);
        check("R10 rx dlvl", rx_dlvl_rd, 7);
        ctrl_en = 1'b0;
        wr(3, 5);
        check("R10 unlocked", rx_thr_rd, 5);

        // R7 and R8 DMA requests
        for (int en = 0; en < 4; en++) begin
            wr(4, en);
            for (int dl = 0; dl < DEPTH; dl++) begin
                wr(5, dl);
                wr(6, dl);
                for (int l = 0; l <= DEPTH; l++) begin
                    set_levels(l, l);
                    check("R7 txdma", tx_dma_req, (en[1] && l <= dl) ? 1 : 0);
                    check("R8 rxdma", rx_dma_req, (en[0] && l > dl) ? 1 : 0);
                end
            end
        end
        wr(4, 0);

        // R3 sticky set and hold; no set when not full/empty
        wr(2, 0); wr(3, 0);
        @(negedge clk); tx_level = 4'd7; rx_level = 4'd1; tx_push = 1; rx_pop = 1; rx_push = 1;
        @(negedge clk); tx_push = 0; rx_pop = 0; rx_push = 0; #1;
        check("R3 no spurious", raw_irq[3:1], 0);
        @(negedge clk); tx_level = LVL_W'(DEPTH); tx_push = 1;
        @(negedge clk); tx_push = 0; tx_level = 4'd2; #1;
        check("R3 tx ovf", raw_irq[3:1], 3'b001);
        @(negedge clk); rx_level = 0; rx_pop = 1;
        @(negedge clk); rx_pop = 0; rx_level = 4'd3; #1;
        check("R3 rx unf", raw_irq[3:1], 3'b011);
        @(negedge clk); rx_level = LVL_W'(DEPTH); rx_push = 1;
        @(negedge clk); rx_push = 0; rx_level = 4'd4; #1;
        check("R3 rx ovf", raw_irq[3:1], 3'b111);
        repeat (3) @(negedge clk); #1;
        check("R3 hold", raw_irq[3:1], 3'b111);

        // R4 every clear pattern on a full error vector
        for (int c = 0; c < 16; c++) begin
            set_all_sticky();
            set_levels(4, 4);
            wr(1, c);
            exp = 7;
            if (c[0] || c[3]) exp &= ~1;
            if (c[0] || c[1]) exp &= ~2;
            if (c[0] || c[2]) exp &= ~4;
            check("R4 clear", raw_irq[3:1], exp);
        end

        // R5 event and clear-all together
        set_levels(4, 0);
        @(negedge clk);
        rx_pop = 1; wr_en = 1; wr_sel = 3'd1; wr_data = 8'h01;
        @(negedge clk);
        rx_pop = 0; wr_en = 0; #1;
        check("R5 set wins", raw_irq[3:1], 3'b010);

        // R6 mask sweep: raw all ones, then a partial raw vector
        wr(1, 1);
        wr(2, 7); wr(3, 0);
        set_all_sticky();
        set_levels(0, 5);
        check("R6 raw setup", raw_irq, 5'h1F);
        for (int m = 0; m < 32; m++) begin
            wr(0, m);
            check("R6 masked", masked_irq, m);
            check("R6 irq", irq, (m != 0) ? 1 : 0);
        end
        wr(1, 8'h0A);  // clears rx underflow and tx overflow
        set_levels(DEPTH, 0);
        check("R6 raw partial", raw_irq, 5'b01000);
        for (int m = 0; m < 32; m++) begin
            wr(0, m);
            check("R6 masked p", masked_irq, m & 8);
            check("R6 irq p", irq, ((m & 8) != 0) ? 1 : 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule